// File: doc/BRIEF.md
# Shift-Based Log/Antilog Converter

This block holds two independent combinational converters that sit at the edges of a signed-log datapath. The input path turns a 12-bit two's-complement integer into a signed-log word, and the output path turns a signed-log word back into a saturated 9-bit two's-complement integer. Both use the piecewise-linear shift approximation. The log of a magnitude is the position of its leading one, plus the bits below that one read as a binary fraction. The antilog of a log word is the mantissa 1.frac shifted by the integer part of the log.

A signed-log word has two pieces. The first is a value sign bit, where 1 means negative. The second is a log of 1 + INT_W + FRAC_W bits held in two's complement: bits [8:4] are the signed integer part and bits [3:0] are the fraction. The log word 9'h100 (−16.0) is the smallest log and stands for zero. Neither path has a clock: each output depends only on its own inputs.

Top module: `shift_log_conv`

## Requirements
- R1: An input integer of 0 gives log word 9'h100 (integer −16, fraction 0) with the value sign 0.
- R2: The output value sign is 1 exactly when the input integer is negative.
- R3: The integer field, bits [8:4] of the log word, equals the bit position (0 to 11) of the leading one of the input magnitude.
- R4: The fraction field, bits [3:0], holds the four magnitude bits just below the leading one, truncated, with missing low bits read as 0.
- R5: The whole input range is accepted: −2048 gives log word 9'h0B0 with sign 1, and +2047 gives 9'h0AF with sign 0.
- R6: The output magnitude is (1 + f/16)·2^i, where i is the signed integer field and f is the fraction field, rounded to the nearest integer with ties going away from zero (for example, 9'h00C with i = 0, f = 12 gives 1.75, which becomes 2).
- R7: The output saturates: a positive magnitude above 255 gives 255, and a negative magnitude above 256 gives −256.
- R8: Value sign 1 gives the two's-complement negation of the rounded, saturated magnitude, and value sign 0 gives the magnitude itself.
- R9: The zero log word 9'h100 gives output 0 whatever the value sign.
- R10: The two paths are independent. Changing both input sets at once gives the results each path gives alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fx_in_i | input | 12 | Two's-complement integer to convert to log form |
| lw_out_o | output | 9 | Log word from the input path |
| sgn_out_o | output | 1 | Value sign from the input path (1 = negative) |
| lw_in_i | input | 9 | Log word to convert to an integer |
| sgn_in_i | input | 1 | Value sign for the output path |
| fx_out_o | output | 9 | Saturated two's-complement integer from the output path |

## Verification
The log and antilog paths share no logic, but both settle together whenever both input sets change in the same step. The bench drives new words into both paths at the same moment, including the case where the output of one path is fed straight back into the other. It then checks each result against a bench model of that path alone. Round-trip values such as −5 are judged on their own: the log path must give 9'h024 and, in the same step, the antilog path must give −5.

// File: rtl/shift_log_pkg.sv
package shift_log_pkg;
  localparam int unsigned DEF_IN_W   = 12;
  localparam int unsigned DEF_OUT_W  = 9;
  localparam int unsigned DEF_INT_W  = 4;
  localparam int unsigned DEF_FRAC_W = 4;

  function automatic int unsigned lw_width(int unsigned int_w, int unsigned frac_w);
    return int_w + 1 + frac_w;
  endfunction
endpackage

// File: rtl/lead_one_enc.sv
module lead_one_enc #(
  parameter int unsigned W  = 12,
  localparam int unsigned PW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic [PW-1:0] pos_o,
  output logic          any_o
);
  always_comb begin
    pos_o = '0;
    any_o = 1'b0;
    for (int k = 0; k < int'(W); k++) begin
      if (vec_i[k]) begin
        pos_o = PW'(k);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/log_in_conv.sv
module log_in_conv #(
  parameter int unsigned IN_W   = 12,
  parameter int unsigned INT_W  = 4,
  parameter int unsigned FRAC_W = 4,
  localparam int unsigned LW    = INT_W + 1 + FRAC_W,
  localparam int unsigned PW    = $clog2(IN_W)
) (
  input  logic [IN_W-1:0] fx_i,
  output logic [LW-1:0]   lw_o,
  output logic            sgn_o
);
  localparam logic [LW-1:0] LW_MIN = {1'b1, {(LW-1){1'b0}}};

  logic [IN_W-1:0]   mag;
  logic [IN_W-1:0]   aligned;
  logic [PW-1:0]     pos;
  logic              nz;
  logic [FRAC_W-1:0] frac;

  assign mag = fx_i[IN_W-1] ? IN_W'(-fx_i) : fx_i;

  lead_one_enc #(.W(IN_W)) u_enc (
    .vec_i (mag),
    .pos_o (pos),
    .any_o (nz)
  );

  // leading one moved to the MSB; fraction sits right below it
  assign aligned = mag << (PW'(IN_W - 1) - pos);
  assign frac    = aligned[IN_W-2 -: FRAC_W];

  always_comb begin
    if (nz) lw_o = {(INT_W + 1)'(pos), frac};
    else    lw_o = LW_MIN;
  end

  assign sgn_o = fx_i[IN_W-1];

  always_comb begin
    if (!$isunknown(fx_i)) begin
      // R1
      zero_map_chk: assert ((fx_i != '0) || (lw_o == LW_MIN && !sgn_o));
      // R3
      lead_pos_chk: assert ((fx_i == '0) || ((mag >> lw_o[LW-1:FRAC_W]) == IN_W'(1)));
      // R2
      sign_chk: assert ((fx_i == '0) || (sgn_o == ($signed(fx_i) < 0)));
      // R3
      int_nonneg_chk: assert ((fx_i == '0) || !lw_o[LW-1]);
    end
  end
endmodule

// File: rtl/antilog_out_conv.sv
module antilog_out_conv #(
  parameter int unsigned OUT_W  = 9,
  parameter int unsigned INT_W  = 4,
  parameter int unsigned FRAC_W = 4,
  localparam int unsigned LW    = INT_W + 1 + FRAC_W,
  localparam int unsigned BIAS  = 2 ** INT_W,
  localparam int unsigned WIDE  = FRAC_W + 1 + BIAS + OUT_W + 1
) (
  input  logic [LW-1:0]    lw_i,
  input  logic             sgn_i,
  output logic [OUT_W-1:0] fx_o
);
  localparam logic [LW-1:0]   LW_MIN  = {1'b1, {(LW-1){1'b0}}};
  localparam logic [OUT_W:0]  POS_LIM = (OUT_W+1)'(2 ** (OUT_W - 1) - 1);
  localparam logic [OUT_W:0]  NEG_LIM = (OUT_W+1)'(2 ** (OUT_W - 1));
  localparam logic [WIDE-1:0] HALF    = WIDE'(1) << (FRAC_W + BIAS - 1);

  logic signed [INT_W:0] ip;
  logic [FRAC_W-1:0]     fr;
  logic [WIDE-1:0]       scaled;
  logic [WIDE-1:0]       rnd;
  logic [OUT_W:0]        mag;
  logic [OUT_W:0]        lim_mag;
  int                    sh;

  assign ip = $signed(lw_i[LW-1:FRAC_W]);
  assign fr = lw_i[FRAC_W-1:0];

  always_comb begin
    // bias shift so negative logs stay in range; clip where saturation is certain
    sh = int'(ip) + int'(BIAS);
    if (sh > int'(OUT_W + BIAS)) sh = int'(OUT_W + BIAS);
    scaled = WIDE'({1'b1, fr}) << sh;
    rnd    = (scaled + HALF) >> (FRAC_W + BIAS);
    mag    = rnd[OUT_W:0];
  end

  always_comb begin
    if (sgn_i) lim_mag = (mag > NEG_LIM) ? NEG_LIM : mag;
    else       lim_mag = (mag > POS_LIM) ? POS_LIM : mag;
    fx_o = sgn_i ? OUT_W'(-lim_mag) : OUT_W'(lim_mag);
  end

  always_comb begin
    if (!$isunknown({lw_i, sgn_i})) begin
      // R9
      zero_out_chk: assert ((lw_i != LW_MIN) || (fx_o == '0));
      // R8
      sign_dir_chk: assert (sgn_i ? ($signed(fx_o) <= 0) : ($signed(fx_o) >= 0));
      // R6
      unity_chk: assert ((lw_i != '0) || (fx_o == (sgn_i ? {OUT_W{1'b1}} : OUT_W'(1))));
      // R7
      sat_hi_chk: assert (!(ip >= $signed((INT_W+1)'(OUT_W - 1))) ||
                          (fx_o == (sgn_i ? OUT_W'(NEG_LIM) : OUT_W'(POS_LIM))));
    end
  end
endmodule

// File: rtl/shift_log_conv.sv
module shift_log_conv
  import shift_log_pkg::*;
#(
  parameter int unsigned IN_W   = DEF_IN_W,
  parameter int unsigned OUT_W  = DEF_OUT_W,
  parameter int unsigned INT_W  = DEF_INT_W,
  parameter int unsigned FRAC_W = DEF_FRAC_W,
  localparam int unsigned LW    = INT_W + 1 + FRAC_W
) (
  input  logic [IN_W-1:0]  fx_in_i,
  output logic [LW-1:0]    lw_out_o,
  output logic             sgn_out_o,
  input  logic [LW-1:0]    lw_in_i,
  input  logic             sgn_in_i,
  output logic [OUT_W-1:0] fx_out_o
);
  log_in_conv #(.IN_W(IN_W), .INT_W(INT_W), .FRAC_W(FRAC_W)) u_log (
    .fx_i  (fx_in_i),
    .lw_o  (lw_out_o),
    .sgn_o (sgn_out_o)
  );

  antilog_out_conv #(.OUT_W(OUT_W), .INT_W(INT_W), .FRAC_W(FRAC_W)) u_alog (
    .lw_i  (lw_in_i),
    .sgn_i (sgn_in_i),
    .fx_o  (fx_out_o)
  );
endmodule

// File: tb/shift_log_conv_tb_top.sv
module shift_log_conv_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [11:0] fx_in;
  logic [8:0]  lw_out;
  logic        sgn_out;
  logic [8:0]  lw_in;
  logic        sgn_in;
  logic [8:0]  fx_out;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  shift_log_conv dut_i (
    .fx_in_i   (fx_in),
    .lw_out_o  (lw_out),
    .sgn_out_o (sgn_out),
    .lw_in_i   (lw_in),
    .sgn_in_i  (sgn_in),
    .fx_out_o  (fx_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model_in(input int x, output int lw, output int s);
    int m, p;
    if (x == 0) begin lw = 256; s = 0; return; end
    s = (x < 0) ? 1 : 0;
    m = (x < 0) ? -x : x;
    p = 0;
    while ((1 << (p + 1)) <= m) p++;
    lw = p * 16 + (((m - (1 << p)) * 16) >> p);
  endfunction

  function automatic int model_out(input int lw9, input int s);
    int l, ip, f, m;
    real v;
    l  = (lw9 >= 256) ? lw9 - 512 : lw9;
    ip = l >>> 4;
    f  = l & 15;
    v  = ((16.0 + f) / 16.0) * (2.0 ** ip);
    m  = int'($floor(v + 0.5));
    if (s != 0) begin if (m > 256) m = 256; return -m; end
    if (m > 255) m = 255;
    return m;
  endfunction

  task automatic apply_in(input int x);
    @(negedge clk); fx_in = 12'(x); #2;
  endtask

  task automatic apply_out(input int lw, input int s);
    @(negedge clk); lw_in = 9'(lw); sgn_in = s[0]; #2;
  endtask

  task automatic t_reset;
    chk("R1 rst lw", int'(lw_out), 256);
    chk("R1 rst sgn", int'(sgn_out), 0);
    chk("R6 rst fx", int'($signed(fx_out)), 1);
  endtask

  task automatic t_zero;
    apply_in(0);
    chk("R1 zero lw", int'(lw_out), 256);
    chk("R1 zero sgn", int'(sgn_out), 0);
  endtask

  task automatic t_fields;
    apply_in(3);
    chk("R3 R4 x=3 lw", int'(lw_out), 'h18);
    apply_in(-5);
    chk("R4 x=-5 lw", int'(lw_out), 'h24);
    chk("R2 x=-5 sgn", int'(sgn_out), 1);
    apply_in(1);
    chk("R3 x=1 lw", int'(lw_out), 0);
    chk("R2 x=1 sgn", int'(sgn_out), 0);
  endtask

  task automatic t_extremes;
    apply_in(-2048);
    chk("R5 -2048 lw", int'(lw_out), 'hB0);
    chk("R5 -2048 sgn", int'(sgn_out), 1);
    apply_in(2047);
    chk("R5 2047 lw", int'(lw_out), 'hAF);
    chk("R5 2047 sgn", int'(sgn_out), 0);
  endtask

  task automatic t_in_sweep;
    int el, es;
    for (int x = -2048; x < 2048; x++) begin
      apply_in(x);
      model_in(x, el, es);
      chk("R3 R4 sweep lw", int'(lw_out), el);
      chk("R2 sweep sgn", int'(sgn_out), es);
    end
  endtask

  task automatic t_out_points;
    apply_out('h00C, 0); chk("R6 1.75", int'($signed(fx_out)), 2);
    apply_out('h1F0, 0); chk("R6 tie 0.5", int'($signed(fx_out)), 1);
    apply_out('h1EF, 0); chk("R6 below half", int'($signed(fx_out)), 0);
    apply_out('h033, 0); chk("R6 tie 9.5", int'($signed(fx_out)), 10);
    apply_out('h033, 1); chk("R8 tie -9.5", int'($signed(fx_out)), -10);
    apply_out('h071, 0); chk("R6 136", int'($signed(fx_out)), 136);
    apply_out('h071, 1); chk("R8 -136", int'($signed(fx_out)), -136);
  endtask

  task automatic t_saturate;
    apply_out('h080, 0); chk("R7 256 pos", int'($signed(fx_out)), 255);
    apply_out('h080, 1); chk("R7 256 neg", int'($signed(fx_out)), -256);
    apply_out('h0FF, 0); chk("R7 max pos", int'($signed(fx_out)), 255);
    apply_out('h0FF, 1); chk("R7 max neg", int'($signed(fx_out)), -256);
    apply_out('h07F, 0); chk("R7 248", int'($signed(fx_out)), 248);
  endtask

  task automatic t_zero_out;
    apply_out('h100, 0); chk("R9 zero pos", int'($signed(fx_out)), 0);
    apply_out('h100, 1); chk("R9 zero neg", int'($signed(fx_out)), 0);
  endtask

  task automatic t_out_sweep;
    for (int s = 0; s < 2; s++)
      for (int l = 0; l < 512; l++) begin
        apply_out(l, s);
        chk("R6 R7 R8 sweep", int'($signed(fx_out)), model_out(l, s));
      end
  endtask

  task automatic t_concurrent;
    int el, es;
    @(negedge clk);
    fx_in = 12'hFFB; lw_in = 9'h024; sgn_in = 1'b1; #2;
    chk("R10 both lw", int'(lw_out), 'h24);
    chk("R10 both fx", int'($signed(fx_out)), -5);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      fx_in  = 12'(k * 97 - 1900);
      lw_in  = 9'(k * 13 + 130);
      sgn_in = k[0];
      #2;
      model_in(k * 97 - 1900, el, es);
      chk("R10 pair lw", int'(lw_out), el);
      chk("R10 pair fx", int'($signed(fx_out)), model_out((k * 13 + 130) % 512, k % 2));
    end
  endtask

  initial begin
    fx_in = '0; lw_in = '0; sgn_in = 1'b0;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk); #2;
    t_reset();
    t_zero();
    t_fields();
    t_extremes();
    t_in_sweep();
    t_out_points();
    t_saturate();
    t_zero_out();
    t_out_sweep();
    t_concurrent();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule